// File: doc/BRIEF.md
# Suspendable Host-Port FIFO DMA Engine

This block sits between a multiplexed external host bus and on-chip memory. Host writes go into a write-posting queue, and a DMA sequencer later copies them to memory. Host reads are served from a read-ahead queue, which the same sequencer keeps topped up from consecutive memory words. The host side sees only a push/pop port and a single not-ready line. That line rises only when the queue needed for the current host cycle cannot serve it.

A debug-suspend input can freeze the DMA side. Two control bits, a free-run bit and a soft-stop bit, select whether the block obeys the input. When suspend is obeyed, any memory transfer already in flight completes and no new transfer starts. The host port stays live the whole time, limited only by queue space and queue contents. When suspend ends, the sequencer catches up on posted writes and on the read-ahead fill. A flush input discards both queues and restarts the read-ahead at a supplied address. The flush waits until any memory transfer in flight has been acknowledged.

Top module: `hport_fifo_dma`

## Requirements
- R1: A host write (`host_wr`) completes in any cycle where the write queue (8 entries) is not full, and `host_wait` is high in every cycle where `host_wr` is high and the queue is full.
- R2: A host read (`host_rd`) returns the oldest read-ahead word on `host_rdata` and consumes it when the queue is not empty, and `host_wait` is high while `host_rd` is high and the queue is empty.
- R3: Posted writes reach memory in host order, each with `mem_we`=1 and the address and data the host supplied. A write leaves the queue only when `mem_ack` arrives.
- R4: The read-ahead fetches consecutive word addresses with `mem_we`=0. It starts at 0 after reset and at `rd_start` after a flush, and stores `mem_rdata` on each `mem_ack` until the queue holds 8 words.
- R5: When the sequencer is idle and free to start, a non-empty write queue is always served before any read-ahead fetch.
- R6: At most one memory request is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from issue until the cycle of `mem_ack`.
- R7: With `ctl_free`=0, `ctl_soft`=1 and `susp_in`=1, no new memory request is issued, while a request already in flight still completes.
- R8: With `ctl_free`=1 (any `ctl_soft`), or with `ctl_free`=0 and `ctl_soft`=0, `susp_in` has no effect on DMA servicing.
- R9: During an obeyed suspend the host may keep writing until the write queue is full and keep reading until the read queue is empty. A host cycle that is held off keeps `host_wait` high through the suspend and completes once the sequencer serves that queue after suspend ends.
- R10: A one-cycle `flush_req` is remembered and takes effect only once no memory request is outstanding. It then empties both queues, discarding their contents, and reloads the read-ahead address from `rd_start`.
- R11: After reset both queues are empty and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write cycle active |
| host_rd | input | 1 | Host read cycle active |
| host_addr | input | AW | Memory word address for a host write |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Oldest read-ahead word |
| host_wait | output | 1 | Host cycle cannot complete this cycle |
| susp_in | input | 1 | Debug-suspend request |
| ctl_free | input | 1 | Free-run: ignore suspend |
| ctl_soft | input | 1 | Soft-stop: obey suspend when free-run is 0 |
| flush_req | input | 1 | Pulse: discard both queues |
| rd_start | input | AW | Read-ahead start address loaded on flush |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Request write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The main function is exercised with four patterns:
- Reads alone against a full read-ahead queue. This separates correct address sequencing from stale or skipped words.
- Posted writes mixed with pending read-ahead. This shows whether write priority and ordering hold.
- Each of the three suspend control settings with suspend raised, with a full write queue and an empty read queue held off across the suspend. This separates obeyed from ignored suspend and shows whether held-off cycles finish after resume.
- A flush raised while a memory request is stalled. This shows whether the flush waits for the acknowledge, and whether the discarded writes and read-ahead words ever reappear.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int HP_DW    = 32;
  localparam int HP_AW    = 16;
  localparam int HP_DEPTH = 8;

  typedef enum logic [0:0] {
    DMA_IDLE = 1'b0,
    DMA_BUSY = 1'b1
  } dma_state_e;
endpackage

// File: rtl/hport_fifo.sv
module hport_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] PTR_ONE = 1;

  logic [PW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [W-1:0] store_q [DEPTH];
  logic         wr_en, rd_en;

  // pointers carry one wrap bit above the index
  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[PW] != rptr_q[PW]) && (wptr_q[PW-1:0] == rptr_q[PW-1:0]);
  assign dout  = store_q[rptr_q[PW-1:0]];

  always_comb begin
    wr_en  = push && !full && !clr;
    rd_en  = pop && !empty && !clr;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (wr_en) wptr_d = wptr_q + PTR_ONE;
      if (rd_en) rptr_d = rptr_q + PTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wptr_q[PW-1:0]] <= din;
  end

  assert_push_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clr) |=> !empty);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !full));
endmodule

// File: rtl/hport_dma_ctrl.sv
module hport_dma_ctrl
  import hport_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          flush_req,
  input  logic [AW-1:0] rd_start,
  input  logic          wr_empty,
  input  logic [AW-1:0] wr_head_addr,
  input  logic [DW-1:0] wr_head_data,
  input  logic          rd_full,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wr_pop,
  output logic          rd_push,
  output logic [DW-1:0] rd_push_data,
  output logic          fifo_clr
);
  localparam logic [AW-1:0] ADDR_ONE = 1;

  dma_state_e    state_q, state_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [AW-1:0] fetch_q, fetch_d;
  logic          fpend_q, fpend_d;
  logic          issue;

  assign mem_req      = (state_q == DMA_BUSY);
  assign mem_we       = we_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign rd_push_data = mem_rdata;

  always_comb begin
    state_d  = state_q;
    we_d     = we_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    fetch_d  = fetch_q;
    fpend_d  = fpend_q | flush_req;
    fifo_clr = 1'b0;
    wr_pop   = 1'b0;
    rd_push  = 1'b0;
    issue    = 1'b0;
    unique case (state_q)
      DMA_IDLE: begin
        if (fpend_q) begin
          fifo_clr = 1'b1;
          fetch_d  = rd_start;
          fpend_d  = flush_req;
        end else if (!halt && !wr_empty) begin
          issue   = 1'b1;
          state_d = DMA_BUSY;
          we_d    = 1'b1;
          addr_d  = wr_head_addr;
          wdata_d = wr_head_data;
        end else if (!halt && !rd_full) begin
          issue   = 1'b1;
          state_d = DMA_BUSY;
          we_d    = 1'b0;
          addr_d  = fetch_q;
        end
      end
      DMA_BUSY: begin
        if (mem_ack) begin
          state_d = DMA_IDLE;
          if (we_q) begin
            wr_pop = 1'b1;
          end else begin
            rd_push = 1'b1;
            fetch_d = fetch_q + ADDR_ONE;
          end
        end
      end
      default: state_d = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DMA_IDLE;
      fpend_q <= 1'b0;
      fetch_q <= '0;
    end else begin
      state_q <= state_d;
      fpend_q <= fpend_d;
      fetch_q <= fetch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue) begin
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_halt_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !mem_req) |=> !mem_req);

  assert_write_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !halt && !fpend_q && !wr_empty) |=> (mem_req && mem_we));

  assert_flush_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fpend_q && mem_req && !mem_ack) |=> (fpend_q && mem_req));
endmodule

// File: rtl/hport_fifo_dma.sv
module hport_fifo_dma
  import hport_pkg::*;
#(
  parameter int DW    = HP_DW,
  parameter int AW    = HP_AW,
  parameter int DEPTH = HP_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_wait,
  input  logic          susp_in,
  input  logic          ctl_free,
  input  logic          ctl_soft,
  input  logic          flush_req,
  input  logic [AW-1:0] rd_start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int WQW = AW + DW;

  logic [1:0]     rst_pipe_q;
  logic           rst_int_n;
  logic           halt;
  logic           wr_full, wr_empty, wr_pop;
  logic           rd_full, rd_empty, rd_push;
  logic [DW-1:0]  rd_push_data;
  logic [WQW-1:0] wq_head;
  logic           fifo_clr;
  logic           host_wr_ok, host_rd_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign halt       = susp_in && !ctl_free && ctl_soft;
  assign host_wr_ok = host_wr && !wr_full;
  assign host_rd_ok = host_rd && !rd_empty;
  assign host_wait  = (host_wr && wr_full) || (host_rd && rd_empty);

  hport_fifo #(.W(WQW), .DEPTH(DEPTH)) u_wq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (fifo_clr),
    .push  (host_wr_ok),
    .pop   (wr_pop),
    .din   ({host_addr, host_wdata}),
    .dout  (wq_head),
    .full  (wr_full),
    .empty (wr_empty)
  );

  hport_fifo #(.W(DW), .DEPTH(DEPTH)) u_rq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (fifo_clr),
    .push  (rd_push),
    .pop   (host_rd_ok),
    .din   (rd_push_data),
    .dout  (host_rdata),
    .full  (rd_full),
    .empty (rd_empty)
  );

  hport_dma_ctrl #(.AW(AW), .DW(DW)) u_dma (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .halt         (halt),
    .flush_req    (flush_req),
    .rd_start     (rd_start),
    .wr_empty     (wr_empty),
    .wr_head_addr (wq_head[WQW-1:DW]),
    .wr_head_data (wq_head[DW-1:0]),
    .rd_full      (rd_full),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .wr_pop       (wr_pop),
    .rd_push      (rd_push),
    .rd_push_data (rd_push_data),
    .fifo_clr     (fifo_clr)
  );

  assert_ignore_susp_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((ctl_free || !ctl_soft) && !mem_req && !wr_empty && !fifo_clr) |=> mem_req);

  assert_reset_idle_R11: assert property (@(posedge clk)
    (!rst_int_n) |-> (!mem_req && wr_empty && rd_empty));
endmodule

// File: tb/sim_hport_fifo_dma.sv
module sim_hport_fifo_dma;
  localparam int DW  = 32;
  localparam int AW  = 16;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr, host_rd;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_wait;
  logic          susp_in, ctl_free, ctl_soft, flush_req;
  logic [AW-1:0] rd_start;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  int posted = 0;
  int prev_posted = 0;
  int lat = 0;
  logic stall = 1'b0;
  logic req_q = 1'b0;
  logic halt_prev = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-1:0] exp_rd_addr = '0;
  logic w9_done = 1'b0;
  logic r9_done = 1'b0;
  logic [AW-1:0] wq_addr[$];
  logic [DW-1:0] wq_data[$];

  always #4 clk = ~clk;

  hport_fifo_dma u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .susp_in(susp_in), .ctl_free(ctl_free),
    .ctl_soft(ctl_soft), .flush_req(flush_req), .rd_start(rd_start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {16'h5A3C, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: posts a host write; expected memory write goes into the scoreboard
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    #1;
    while (host_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    wq_addr.push_back(a);
    wq_data.push_back(d);
    posted++;
    host_wr = 1'b0;
  endtask

  task automatic do_read(input string tag);
    logic [DW-1:0] got, exp;
    @(negedge clk);
    host_rd = 1'b1;
    #1;
    while (host_wait) begin @(negedge clk); #1; end
    got = host_rdata;
    exp = mem_word(exp_rd_addr);
    exp_rd_addr = exp_rd_addr + 1'b1;
    check(got == exp, tag, got, exp);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // memory model and monitor: pops expected writes, checks ordering rules
  always @(negedge clk) begin
    logic ack_was;
    #2;
    ack_was = mem_ack;
    if (!rst_n) begin
      mem_ack = 1'b0; lat = 0; req_q = 1'b0; prev_posted = 0; halt_prev = 1'b0;
    end else begin
      if (halt_prev)
        check(!(mem_req && !req_q), "R7 new request while suspended", {31'd0, mem_req}, 32'd0);
      if (mem_req && !req_q && prev_posted > 0)
        check(mem_we, "R5 read-ahead before posted write", {31'd0, mem_we}, 32'd1);
      if (mem_req && req_q && !ack_was)
        check(mem_addr == prev_addr, "R6 address changed while pending", {16'd0, mem_addr}, {16'd0, prev_addr});
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && !stall) begin
        if (lat >= LAT) begin
          mem_ack = 1'b1;
          mem_rdata = mem_word(mem_addr);
          lat = 0;
          if (mem_we) begin
            if (wq_addr.size() == 0) begin
              check(1'b0, "R10 discarded or unexpected write reached memory", {16'd0, mem_addr}, 32'd0);
            end else begin
              logic [AW-1:0] ea;
              logic [DW-1:0] ed;
              ea = wq_addr.pop_front();
              ed = wq_data.pop_front();
              check(mem_addr == ea, "R3 write address", {16'd0, mem_addr}, {16'd0, ea});
              check(mem_wdata == ed, "R3 write data", mem_wdata, ed);
              posted--;
            end
          end
        end else begin
          lat++;
        end
      end
      req_q = mem_req;
      prev_addr = mem_addr;
      prev_posted = posted;
      halt_prev = susp_in && !ctl_free && ctl_soft;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    susp_in = 1'b0; ctl_free = 1'b0; ctl_soft = 1'b0; flush_req = 1'b0;
    rd_start = 16'h0400; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check(mem_req == 1'b0, "R11 mem_req in reset", {31'd0, mem_req}, 32'd0);
    check(host_wait == 1'b0, "R11 host_wait idle in reset", {31'd0, host_wait}, 32'd0);
    host_rd = 1'b1; #1;
    check(host_wait == 1'b1, "R2 R11 read on empty queue waits", {31'd0, host_wait}, 32'd1);
    host_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R4 / R2: read-ahead from address 0 upward
    for (int i = 0; i < 10; i++) do_read("R4 read-ahead word after reset");

    // R1 / R3 / R5: writes mixed with pending read-ahead
    do_write(16'h0100, 32'hCAFE0001);
    do_write(16'h0107, 32'hCAFE0002);
    do_read("R2 read while writes drain");
    do_write(16'h0033, 32'hCAFE0003);
    repeat (40) @(negedge clk);
    check(wq_addr.size() == 0, "R3 all posted writes drained", wq_addr.size(), 0);

    // R7 / R9 / R1: obeyed suspend, write queue fills, ninth write held
    @(negedge clk); susp_in = 1'b1; ctl_free = 1'b0; ctl_soft = 1'b1;
    for (int i = 0; i < 8; i++) do_write(16'h0200 + 16'(i), 32'hB0000000 + i);
    check(wq_addr.size() == 8, "R9 eight writes posted during suspend", wq_addr.size(), 8);
    fork
      begin do_write(16'h02FF, 32'hB00000FF); w9_done = 1'b1; end
    join_none
    begin
      bit held = 1'b1;
      repeat (10) begin @(negedge clk); #3; if (!host_wait) held = 1'b0; end
      check(held, "R1 R9 host_wait held while write queue full", {31'd0, held}, 32'd1);
    end
    @(negedge clk); susp_in = 1'b0;
    wait (w9_done);
    repeat (60) @(negedge clk);
    check(wq_addr.size() == 0, "R9 posted writes drained after resume", wq_addr.size(), 0);

    // R9: read queue empties under suspend, ninth read held then served
    @(negedge clk); susp_in = 1'b1;
    for (int i = 0; i < 8; i++) do_read("R9 read during suspend");
    fork
      begin do_read("R9 held read completes after resume"); r9_done = 1'b1; end
    join_none
    begin
      bit held = 1'b1;
      repeat (10) begin @(negedge clk); #3; if (!host_wait) held = 1'b0; end
      check(held, "R2 R9 host_wait held while read queue empty", {31'd0, held}, 32'd1);
    end
    @(negedge clk); susp_in = 1'b0;
    wait (r9_done);
    repeat (40) @(negedge clk);

    // R8: suspend ignored with free-run set, and with soft-stop clear
    @(negedge clk); susp_in = 1'b1; ctl_free = 1'b1; ctl_soft = 1'b1;
    do_write(16'h0300, 32'hD0000001);
    do_write(16'h0301, 32'hD0000002);
    repeat (30) @(negedge clk);
    check(wq_addr.size() == 0, "R8 free-run drains during suspend", wq_addr.size(), 0);
    @(negedge clk); ctl_free = 1'b0; ctl_soft = 1'b0;
    do_write(16'h0302, 32'hD0000003);
    for (int i = 0; i < 9; i++) do_read("R8 soft-stop clear keeps read-ahead");
    repeat (30) @(negedge clk);
    check(wq_addr.size() == 0, "R8 soft-stop clear drains during suspend", wq_addr.size(), 0);
    @(negedge clk); susp_in = 1'b0;
    repeat (30) @(negedge clk);

    // R10: flush raised while a read-ahead fetch is stalled
    @(negedge clk); stall = 1'b1;
    do_read("R4 read before flush");
    do_write(16'h0500, 32'hEE000001);
    do_write(16'h0501, 32'hEE000002);
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    repeat (5) @(negedge clk);
    #3;
    check(mem_req && !mem_we, "R10 flush waits for outstanding fetch", {30'd0, mem_req, mem_we}, 32'd2);
    wq_addr.delete(); wq_data.delete(); posted = 0;
    exp_rd_addr = rd_start;
    @(negedge clk); stall = 1'b0;
    repeat (60) @(negedge clk);
    for (int i = 0; i < 4; i++) do_read("R10 R4 read-ahead restarts at rd_start");
    repeat (10) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule